// File: doc/BRIEF.md
# Flash Read-Protection Register with Commit

This block holds one read-enable bit for each 2 KB block of a 64 KB flash region. A set bit leaves the block open for reads; a cleared bit protects it. Software reaches the bits through a small memory-mapped register port, which has an address, a write strobe, write data and registered read data. The register answers at two bus offsets that share the same storage. A write can only turn bits off. The bits it turns off stay in a working bank until a commit strobe copies the working bank into a non-volatile bank. From then on those bits stay cleared for good.

Two reset inputs act differently. A power-on reset reloads the working bank from the non-volatile bank, so any clear that was never committed is lost. A general system reset leaves both banks alone and only clears the read-data register. A factory-init input sets the non-volatile bank to all ones, which stands in for the programmed state. A combinational query port takes a flash byte address and reports whether reads from the block that holds that address are enabled.

Top module: `flash_rdprot_reg`

## Requirements
- R1: Bit n of the register governs the 2 KB block at byte addresses n*2048 to n*2048+2047. For a query address below 64 KB, `qry_rd_en` equals the bit selected by `qry_addr[15:11]`.
- R2: After factory init and a power-on reset, the register reads 0xFFFFFFFF and every in-range query returns 1.
- R3: A write to a mapped offset sets the working value to old AND `reg_wdata`. Writing 1 over a 0 leaves the bit at 0.
- R4: A one-cycle `commit_req` copies the working value into the non-volatile bank.
- R5: Power-on reset reloads the working value from the non-volatile bank, which discards uncommitted clears.
- R6: Offsets 0x130 and 0x200 reach the same storage, for reads and for writes.
- R7: A read at any other offset returns 0 one cycle later. A write at any other offset changes nothing.
- R8: Once a bit has been committed as 0, no write, commit, system reset or power-on reset can return it to 1.
- R9: A query address of 64 KB or above, where `qry_addr[16]` is 1, returns 1.
- R10: When a write and a commit fall in the same cycle, the commit stores the value after the write.
- R11: System reset clears `reg_rdata` to 0 and leaves the working value unchanged. `reg_rdata` shows the addressed value one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asserted asynchronously and released synchronously |
| sys_rst_n | input | 1 | General system reset, active low |
| factory_init | input | 1 | Sets the non-volatile bank to all ones |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data; each 0 bit clears the matching bit |
| reg_rdata | output | 32 | Registered read data |
| commit_req | input | 1 | One-cycle commit strobe |
| qry_addr | input | 17 | Flash byte address to look up |
| qry_rd_en | output | 1 | 1 when reads from the addressed block are enabled |

## Verification
The bench writes 1 over bits that are already cleared and checks that they stay at 0. A design that stored the write data directly would reopen those blocks. It sends a write and a commit in the same cycle, then runs power-on reset, to show that the non-volatile bank captured the value after the write. A design that latched the old working value would lose that clear after the reset. Uncommitted clears must survive a system reset and disappear after a power-on reset, and committed clears must survive writes of all ones followed by both kinds of reset. The bench also probes unmapped offsets such as 0x134 and 0x330, which would catch a partial address decode. It queries 0x1C000, which would catch a lookup that ignores bit 16 and wraps onto the protected block 24.

// File: rtl/rdprot_pkg.sv
package rdprot_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned BLK_LOG2   = 11;
  localparam int unsigned REG_ADDR_W = 12;
  localparam int unsigned QADDR_W    = 17;
  localparam int unsigned RST_STAGES = 2;
  localparam logic [REG_ADDR_W-1:0] OFFS_PRI = 12'h130;
  localparam logic [REG_ADDR_W-1:0] OFFS_ALT = 12'h200;
  typedef logic [REG_W-1:0] prot_vec_t;
endpackage

// File: rtl/rdprot_rst_sync.sv
module rdprot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rdprot_bus_if.sv
module rdprot_bus_if #(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32,
  parameter int unsigned NALIAS = 2,
  parameter logic [NALIAS*AW-1:0] ALIASES = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] cur_val,
  output logic          wr_hit,
  output logic [DW-1:0] rdata
);
  logic [NALIAS-1:0] hit_vec;
  logic              addr_hit;
  logic [DW-1:0]     rdata_d;
  logic [DW-1:0]     rdata_q;

  // one comparator per alias offset
  for (genvar i = 0; i < NALIAS; i++) begin : g_alias
    assign hit_vec[i] = (addr == ALIASES[i*AW +: AW]);
  end

  assign addr_hit = |hit_vec;
  assign wr_hit   = we & addr_hit;

  always_comb begin
    rdata_d = addr_hit ? cur_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // unmapped offsets read back as zero
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |=> (rdata == '0));
  // never more than one alias matches
  p_single_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/rdprot_bits.sv
module rdprot_bits #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         por_ok,
  input  logic         factory_init,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         commit,
  output logic [W-1:0] work
);
  logic [W-1:0] work_q, work_d, work_nx;
  logic         work_en;
  logic [W-1:0] nv_q, nv_nx;
  logic         nv_en;
  logic         commit_ok;

  // working bank: clear-only writes, reload while power-on reset is held
  always_comb begin
    work_d  = wr_en ? (work_q & wdata) : work_q;
    work_en = !por_ok || wr_en;
    work_nx = por_ok ? work_d : nv_q;
  end

  always_ff @(posedge clk) begin
    if (work_en) work_q <= work_nx;
  end

  // non-volatile bank: factory value or commit of post-write working value
  always_comb begin
    commit_ok = commit && por_ok;
    nv_en     = factory_init || commit_ok;
    nv_nx     = factory_init ? '1 : (nv_q & work_d);
  end

  always_ff @(posedge clk) begin
    if (nv_en) nv_q <= nv_nx;
  end

  assign work = work_q;

  p_wr_clear_only_r3: assert property (@(posedge clk) disable iff (!por_ok)
    $past(por_ok) |-> ((work_q & ~$past(work_q)) == '0));
  p_por_reload_r5: assert property (@(posedge clk) disable iff (factory_init)
    !por_ok |=> (work_q == $past(nv_q)));
  p_commit_capture_r4: assert property (@(posedge clk) disable iff (!por_ok || factory_init)
    commit |=> (nv_q == work_q));
  p_nv_monotone_r8: assert property (@(posedge clk) disable iff (!por_ok)
    !$past(factory_init) |-> ((nv_q & ~$past(nv_q)) == '0));
  p_work_within_nv_r8: assert property (@(posedge clk) disable iff (!por_ok || factory_init)
    ((work_q & ~nv_q) == '0));
endmodule

// File: rtl/rdprot_lookup.sv
module rdprot_lookup #(
  parameter int unsigned W        = 32,
  parameter int unsigned BLK_LOG2 = 11,
  parameter int unsigned QW       = 17
) (
  input  logic [W-1:0]  work,
  input  logic [QW-1:0] qaddr,
  output logic          rd_en
);
  localparam int unsigned IDX_W     = $clog2(W);
  localparam int unsigned SPAN_LOG2 = BLK_LOG2 + IDX_W;

  logic [IDX_W-1:0] idx;
  logic             in_range;

  assign idx = qaddr[SPAN_LOG2-1:BLK_LOG2];

  if (QW > SPAN_LOG2) begin : g_wide
    assign in_range = (qaddr[QW-1:SPAN_LOG2] == '0);
  end else begin : g_exact
    assign in_range = 1'b1;
  end

  assign rd_en = in_range ? work[idx] : 1'b1;

  // a blocked answer only ever comes from inside the covered region
  always_comb begin
    if (rd_en == 1'b0) begin
      p_blocked_in_range_r9: assert (in_range);
    end
  end
endmodule

// File: rtl/flash_rdprot_reg.sv
module flash_rdprot_reg
  import rdprot_pkg::*;
#(
  parameter int unsigned AW  = REG_ADDR_W,
  parameter int unsigned QW  = QADDR_W,
  parameter logic [AW-1:0] OFFS_A = OFFS_PRI,
  parameter logic [AW-1:0] OFFS_B = OFFS_ALT
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             factory_init,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             commit_req,
  input  logic [QW-1:0]    qry_addr,
  output logic             qry_rd_en
);
  localparam int unsigned NALIAS = 2;
  localparam logic [NALIAS*AW-1:0] ALIAS_SET = {OFFS_B, OFFS_A};

  logic      por_ok;
  logic      bus_rst_n;
  logic      any_rst_n;
  logic      wr_hit;
  prot_vec_t work;

  assign any_rst_n = por_n & sys_rst_n;

  rdprot_rst_sync #(.STAGES(RST_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_ok)
  );

  rdprot_rst_sync #(.STAGES(RST_STAGES)) u_bus_sync (
    .clk(clk), .arst_n(any_rst_n), .srst_n(bus_rst_n)
  );

  rdprot_bus_if #(.AW(AW), .DW(REG_W), .NALIAS(NALIAS), .ALIASES(ALIAS_SET)) u_bus (
    .clk(clk), .rst_n(bus_rst_n), .addr(reg_addr), .we(reg_we),
    .cur_val(work), .wr_hit(wr_hit), .rdata(reg_rdata)
  );

  rdprot_bits #(.W(REG_W)) u_bits (
    .clk(clk), .por_ok(por_ok), .factory_init(factory_init),
    .wr_en(wr_hit), .wdata(reg_wdata), .commit(commit_req), .work(work)
  );

  rdprot_lookup #(.W(REG_W), .BLK_LOG2(BLK_LOG2), .QW(QW)) u_lookup (
    .work(work), .qaddr(qry_addr), .rd_en(qry_rd_en)
  );

  // system reset alone never alters the working bank
  p_sysrst_keeps_work_r11: assert property (@(posedge clk) disable iff (!por_ok)
    ($past(por_ok) && !$past(wr_hit)) |-> (work == $past(work)));
endmodule

// File: tb/flash_rdprot_reg_tb_top.sv
`timescale 1ns/1ps
module flash_rdprot_reg_tb_top;
  logic        clk = 1'b0;
  logic        por_n, sys_rst_n, factory_init;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        commit_req;
  logic [16:0] qry_addr;
  logic        qry_rd_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_rdprot_reg dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .factory_init(factory_init),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .commit_req(commit_req), .qry_addr(qry_addr), .qry_rd_en(qry_rd_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic c);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d; commit_req = c;
    @(negedge clk);
    reg_we = 1'b0; commit_req = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic q_chk(input string req, input logic [16:0] a, input logic exp);
    @(negedge clk);
    qry_addr = a;
    #1;
    chk(req, {31'd0, qry_rd_en}, {31'd0, exp});
  endtask

  task automatic por_cycle();
    @(negedge clk); por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R11 rdata after reset", reg_rdata, 32'h0);
    rd_chk("R2 power-on value", 12'h130, 32'hFFFF_FFFF);
    q_chk("R2 open block 0", 17'h00000, 1'b1);
    q_chk("R2 open block 31", 17'h0FFFF, 1'b1);
  endtask

  task automatic t_alias_clear();
    wr(12'h130, 32'hFFFF_00F0, 1'b0);
    rd_chk("R6 alias read", 12'h200, 32'hFFFF_00F0);
    rd_chk("R3 clear applied", 12'h130, 32'hFFFF_00F0);
    wr(12'h200, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R3 ones do not set", 12'h130, 32'hFFFF_00F0);
    wr(12'h200, 32'hF0FF_FFFF, 1'b0);
    rd_chk("R6 alias write", 12'h130, 32'hF0FF_00F0);
  endtask

  task automatic t_lookup();
    q_chk("R1 block 0 blocked", 17'h00000, 1'b0);
    q_chk("R1 block 4 top byte", 17'h027FF, 1'b1);
    q_chk("R1 block 5 open", 17'h02800, 1'b1);
    q_chk("R1 block 8 blocked", 17'h04000, 1'b0);
    q_chk("R1 block 24 blocked", 17'h0C000, 1'b0);
    q_chk("R1 block 31 open", 17'h0FFFF, 1'b1);
    q_chk("R9 64K boundary", 17'h10000, 1'b1);
    q_chk("R9 no wrap to block 24", 17'h1C000, 1'b1);
  endtask

  task automatic t_unmapped();
    rd_chk("R7 unmapped read 0x134", 12'h134, 32'h0);
    wr(12'h134, 32'h0, 1'b0);
    wr(12'h330, 32'h0, 1'b0);
    wr(12'h000, 32'h0, 1'b0);
    rd_chk("R7 unmapped writes ignored", 12'h130, 32'hF0FF_00F0);
  endtask

  task automatic t_sys_reset();
    rd_chk("R11 value before sys reset", 12'h130, 32'hF0FF_00F0);
    @(negedge clk); sys_rst_n = 1'b0;
    #1;
    chk("R11 rdata cleared", reg_rdata, 32'h0);
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R11 working kept", 12'h130, 32'hF0FF_00F0);
  endtask

  task automatic t_por_discard();
    por_cycle();
    rd_chk("R5 uncommitted clears lost", 12'h200, 32'hFFFF_FFFF);
  endtask

  task automatic t_commit();
    wr(12'h130, 32'hFFFF_FF0F, 1'b0);
    wr(12'h200, 32'h7FFF_FFFF, 1'b1);
    rd_chk("R10 post-write value", 12'h130, 32'h7FFF_FF0F);
    wr(12'h130, 32'hFFFF_0FFF, 1'b0);
    rd_chk("R3 further clear", 12'h130, 32'h7FFF_0F0F);
    por_cycle();
    rd_chk("R4 R10 committed value reloaded", 12'h130, 32'h7FFF_FF0F);
  endtask

  task automatic t_permanent();
    wr(12'h130, 32'hFFFF_FFFF, 1'b1);
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    por_cycle();
    rd_chk("R8 committed clears permanent", 12'h200, 32'h7FFF_FF0F);
    q_chk("R8 block 31 stays blocked", 17'h0F800, 1'b0);
    q_chk("R1 block 4 blocked", 17'h02000, 1'b0);
  endtask

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b0; factory_init = 1'b1;
    reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; commit_req = 1'b0; qry_addr = '0;
    repeat (3) @(negedge clk);
    factory_init = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_alias_clear();
    t_lookup();
    t_unmapped();
    t_sys_reset();
    t_por_discard();
    t_commit();
    t_permanent();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule